// File: doc/BRIEF.md
# Reload Down-Counter Timer with Event Flags

This block is a 16-bit down-counting timer on an 8-bit register bus. Software programs a 16-bit reload value and sets a run bit. On every clock cycle while the run bit is set, the counter steps down by one. From zero it reloads the programmed value and raises an end-of-count flag. Three compare registers raise match flags when the running count equals them. Two capture pins store the count on a rising edge. A trip strobe marks the first capture flag as well.

The count is read as two bytes, low byte first. Reading the low byte copies the current high byte into a holding register, and the next high-byte read returns that copy. The 16-bit value software sees is therefore coherent even while the counter runs. The two count addresses are shared: a read returns count data and a write goes to the reload value. The event status register clears on read.

Top module: `reload_timer`

## Requirements
- R1: Register map, with a 4-bit address:
  - 0: count low byte on read, reload low byte on write.
  - 1: held high byte on read, reload high byte on write.
  - 2: status (read only).
  - 3: control, bit 0 is the run bit.
  - 4/5, 6/7, 8/9: compare 0, 1, 2 as low/high byte pairs, read/write.
  - 10/11: capture A low/high, read only.
  - 12/13: capture B low/high, read only.
- R2: Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd` is high. After reset the count, reload, control, status and read data are zero, and every compare register holds 0xFFFF.
- R3: Status bit positions: end-of-count is bit 0, capture A is bit 1, capture B is bit 2, and compares 0, 1 and 2 are bits 3, 4 and 5. A flag reads 1 once its event has happened. A status read returns the flags and clears each one that read as 1. An event in the same cycle as the read leaves its flag set.
- R4: While the run bit is set, the count falls by one each cycle. A cycle that starts at zero loads the reload value instead and sets the end-of-count flag.
- R5: While the run bit is clear, the count does not change.
- R6: Writes to addresses 0 and 1 change only the reload value and leave the live count unchanged.
- R7: A read of address 0 copies the count's high byte into the holding register. A read of address 1 returns that held byte, not the live one.
- R8: Reading any register has no effect on the count.
- R9: A compare flag is set in a cycle where the run bit is set and the count equals that compare register. There is no match while the run bit is clear.
- R10: A rising edge on a capture pin stores the current count in that pin's capture register and sets its flag. A pin held high does not set the flag again.
- R11: A high cycle on `trip_strobe` sets the capture A flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| cap_pin_a | input | 1 | Capture pin A |
| cap_pin_b | input | 1 | Capture pin B |
| trip_strobe | input | 1 | Trip event, sets the capture A flag |

## Verification
The assertions check on every cycle that the counter steps down by one, reloads from zero, and holds still while stopped. They also check that each event sets its flag in the next cycle, that a status read clears only the flags with no event pending, that a capture stores the count of its edge cycle, and that a low-byte read loads the holding register. Only the bench scenarios can show the behaviour seen from the bus. These cover a held high byte that differs from the live one after the counter has moved, reload writes that leave the count alone, a compare that does not fire while the timer is stopped, and a trip arriving in the same cycle as a status read.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
   localparam int ADDR_W = 4;
   // register addresses; count and reload share the first two
   localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd0;
   localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd1;
   localparam logic [ADDR_W-1:0] A_STATUS  = 4'd2;
   localparam logic [ADDR_W-1:0] A_CTRL    = 4'd3;
   localparam logic [ADDR_W-1:0] A_CMP0    = 4'd4;
   localparam logic [ADDR_W-1:0] A_CAPA_LO = 4'd10;
   localparam logic [ADDR_W-1:0] A_CAPA_HI = 4'd11;
   localparam logic [ADDR_W-1:0] A_CAPB_LO = 4'd12;
   localparam logic [ADDR_W-1:0] A_CAPB_HI = 4'd13;
   // status bit positions (decoded by software)
   localparam int F_EOC  = 0;
   localparam int F_CAPA = 1;
   localparam int F_CAPB = 2;
   localparam int F_CMP0 = 3;
   localparam int STAT_W = 6;
   localparam int MAX_CMP = 3;
   localparam int NUM_CAP = 2;
endpackage

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             eoc_pulse
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   assign eoc_pulse = run && (count == ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= ZERO;
      else if (run) begin
         if (count == ZERO)
            count <= reload;
         else
            count <= count - ONE;
      end
   end

   // R4
   reload_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && count == ZERO) |=> (count == $past(reload)));
   // R4
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && count != ZERO) |=> (count == $past(count) - ONE));
   // R5
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count));
endmodule

// File: rtl/rtmr_events.sv
module rtmr_events
   import rtmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_CMP = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            run,
   input  logic [CNT_W-1:0]                count,
   input  logic                            eoc_pulse,
   input  logic [NUM_CAP-1:0]              cap_pin,
   input  logic                            trip,
   input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
   input  logic                            rd_status,
   output logic [STAT_W-1:0]               flags,
   output logic [NUM_CAP-1:0][CNT_W-1:0]   cap_val
);
   logic [STAT_W-1:0]  ev;
   logic [NUM_CAP-1:0] pin_q;
   logic [NUM_CAP-1:0] cap_edge;

   assign cap_edge = cap_pin & ~pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= cap_pin;
   end

   for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
      always_ff @(posedge clk) begin
         if (!rst_n)
            cap_val[c] <= '0;
         else if (cap_edge[c])
            cap_val[c] <= count;
      end
      // R10
      cap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_pin[c] && !pin_q[c]) |=> (cap_val[c] == $past(count)));
   end

   assign ev[F_EOC]  = eoc_pulse;
   assign ev[F_CAPA] = cap_edge[0] | trip;
   assign ev[F_CAPB] = cap_edge[1];

   for (genvar k = 0; k < MAX_CMP; k++) begin : g_cmp
      if (k < NUM_CMP) begin : g_on
         assign ev[F_CMP0+k] = run && (count == cmp_val[k]);
         // R9
         cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && count == cmp_val[k]) |=> flags[F_CMP0+k]);
      end else begin : g_off
         assign ev[F_CMP0+k] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         flags <= '0;
      else if (rd_status)
         flags <= ev;
      else
         flags <= flags | ev;
   end

   // R11
   trip_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> flags[F_CAPA]);
   // R4
   eoc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_pulse |=> flags[F_EOC]);
   for (genvar b = 0; b < STAT_W; b++) begin : g_clr
      // R3
      clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_status && !ev[b]) |=> !flags[b]);
      // R3
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[b] && !rd_status) |=> flags[b]);
   end
endmodule

// File: rtl/rtmr_regs.sv
module rtmr_regs
   import rtmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int BUS_W   = 8,
   parameter int NUM_CMP = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic                            bus_wr,
   input  logic                            bus_rd,
   input  logic [BUS_W-1:0]                bus_wdata,
   input  logic [CNT_W-1:0]                count,
   input  logic [STAT_W-1:0]               flags,
   input  logic [NUM_CAP-1:0][CNT_W-1:0]   cap_val,
   output logic [CNT_W-1:0]                reload,
   output logic                            run,
   output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
   output logic                            rd_status,
   output logic [BUS_W-1:0]                bus_rdata
);
   localparam int HI_W = CNT_W - BUS_W;

   logic [HI_W-1:0]  held_hi;
   logic [BUS_W-1:0] rd_mux;

   assign rd_status = bus_rd && (bus_addr == A_STATUS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload <= '0;
         run    <= 1'b0;
      end else if (bus_wr) begin
         if (bus_addr == A_CNT_LO) reload[BUS_W-1:0]     <= bus_wdata;
         if (bus_addr == A_CNT_HI) reload[CNT_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
         if (bus_addr == A_CTRL)   run                   <= bus_wdata[0];
      end
   end

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
      localparam logic [ADDR_W-1:0] LO = A_CMP0 + ADDR_W'(2*k);
      localparam logic [ADDR_W-1:0] HI = A_CMP0 + ADDR_W'(2*k+1);
      always_ff @(posedge clk) begin
         if (!rst_n)
            cmp_val[k] <= '1;
         else if (bus_wr && bus_addr == LO)
            cmp_val[k][BUS_W-1:0] <= bus_wdata;
         else if (bus_wr && bus_addr == HI)
            cmp_val[k][CNT_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         held_hi <= '0;
      else if (bus_rd && bus_addr == A_CNT_LO)
         held_hi <= count[CNT_W-1:BUS_W];
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         A_CNT_LO:  rd_mux = count[BUS_W-1:0];
         A_CNT_HI:  rd_mux = BUS_W'(held_hi);
         A_STATUS:  rd_mux = BUS_W'(flags);
         A_CTRL:    rd_mux = BUS_W'(run);
         A_CAPA_LO: rd_mux = cap_val[0][BUS_W-1:0];
         A_CAPA_HI: rd_mux = BUS_W'(cap_val[0][CNT_W-1:BUS_W]);
         A_CAPB_LO: rd_mux = cap_val[1][BUS_W-1:0];
         A_CAPB_HI: rd_mux = BUS_W'(cap_val[1][CNT_W-1:BUS_W]);
         default: begin
            for (int k = 0; k < NUM_CMP; k++) begin
               if (bus_addr == A_CMP0 + ADDR_W'(2*k))
                  rd_mux = cmp_val[k][BUS_W-1:0];
               if (bus_addr == A_CMP0 + ADDR_W'(2*k+1))
                  rd_mux = BUS_W'(cmp_val[k][CNT_W-1:BUS_W]);
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_mux;
   end

   // R7
   hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_CNT_LO) |=> (held_hi == $past(count[CNT_W-1:BUS_W])));
   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_addr == A_CNT_LO) |=> $stable(held_hi));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import rtmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int BUS_W   = 8,
   parameter int NUM_CMP = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              cap_pin_a,
   input  logic              cap_pin_b,
   input  logic              trip_strobe
);
   if (CNT_W <= BUS_W || CNT_W > 2*BUS_W) begin : g_bad_width
      $error("reload_timer: CNT_W must fit in two bus bytes");
   end
   if (NUM_CMP < 1 || NUM_CMP > MAX_CMP) begin : g_bad_cmp
      $error("reload_timer: NUM_CMP out of range");
   end

   logic [CNT_W-1:0]                count;
   logic [CNT_W-1:0]                reload;
   logic                            run;
   logic                            eoc_pulse;
   logic                            rd_status;
   logic [STAT_W-1:0]               flags;
   logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val;
   logic [NUM_CAP-1:0][CNT_W-1:0]   cap_val;

   rtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .reload(reload),
      .count(count), .eoc_pulse(eoc_pulse)
   );

   rtmr_events #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_evt (
      .clk(clk), .rst_n(rst_n), .run(run), .count(count),
      .eoc_pulse(eoc_pulse), .cap_pin({cap_pin_b, cap_pin_a}),
      .trip(trip_strobe), .cmp_val(cmp_val), .rd_status(rd_status),
      .flags(flags), .cap_val(cap_val)
   );

   rtmr_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .NUM_CMP(NUM_CMP)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .count(count), .flags(flags),
      .cap_val(cap_val), .reload(reload), .run(run), .cmp_val(cmp_val),
      .rd_status(rd_status), .bus_rdata(bus_rdata)
   );

   // R8
   read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !run) |=> $stable(count));
endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cap_pin_a = 1'b0;
   logic       cap_pin_b = 1'b0;
   logic       trip_strobe = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic rd_q = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb[$];

   always #5 clk = ~clk;

   reload_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_pin_a(cap_pin_a), .cap_pin_b(cap_pin_b), .trip_strobe(trip_strobe)
   );

   always @(posedge clk) rd_q <= bus_rd;

   // monitor: read data is valid one cycle after the strobe (R2)
   always @(negedge clk) begin
      if (rd_q && !done) begin
         item_t it;
         it = sb.pop_front();
         total++;
         if (bus_rdata !== it.exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string tag);
      item_t it;
      it.exp = e; it.tag = tag;
      sb.push_back(it);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // run bit set for exactly n clock edges
   task automatic run_ticks(input int n);
      bus_write(4'd3, 8'h01);
      repeat (n-1) @(negedge clk);
      bus_write(4'd3, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // reset state
      bus_read(4'd2, 8'h00, "R2 reset status");
      bus_read(4'd0, 8'h00, "R2 reset count lo");
      bus_read(4'd1, 8'h00, "R2 reset count hi");
      bus_read(4'd3, 8'h00, "R2 reset control");
      bus_read(4'd5, 8'hFF, "R2 reset compare hi");

      // reload write leaves the stopped count alone
      bus_write(4'd0, 8'h34);
      bus_write(4'd1, 8'h12);
      bus_read(4'd0, 8'h00, "R6 count lo after reload write");
      bus_read(4'd1, 8'h00, "R6 count hi after reload write");

      // one tick from zero reloads and flags end-of-count
      run_ticks(1);
      bus_read(4'd2, 8'h01, "R4 end-of-count flag");
      bus_read(4'd2, 8'h00, "R3 status cleared by read");
      bus_read(4'd0, 8'h34, "R4 reloaded lo");
      bus_read(4'd1, 8'h12, "R4 reloaded hi");
      idle(5);
      bus_read(4'd0, 8'h34, "R5 stopped count lo");

      // coherent high byte: latch 0x12, run to 0x11FF
      run_ticks(8'h35);
      bus_read(4'd1, 8'h12, "R7 held high byte");
      bus_read(4'd0, 8'hFF, "R4 count lo after 0x35 ticks");
      bus_read(4'd1, 8'h11, "R7 fresh high byte");
      bus_read(4'd1, 8'h11, "R8 reads do not move count");

      // compares: 0x11F0 and 0x11F5 hit, 0x1000 not
      bus_write(4'd4, 8'hF0); bus_write(4'd5, 8'h11);
      bus_write(4'd6, 8'hF5); bus_write(4'd7, 8'h11);
      bus_write(4'd8, 8'h00); bus_write(4'd9, 8'h10);
      bus_read(4'd7, 8'h11, "R1 compare 1 hi readback");
      run_ticks(16);
      bus_read(4'd2, 8'h18, "R9 compare 0 and 1 flags");
      bus_read(4'd2, 8'h00, "R3 compare flags cleared");
      // compare equal to the stopped count: no match
      bus_write(4'd8, 8'hEF); bus_write(4'd9, 8'h11);
      idle(4);
      bus_read(4'd2, 8'h00, "R9 no match while stopped");

      // capture A
      cap_pin_a = 1'b1;
      idle(2);
      bus_read(4'd2, 8'h02, "R10 capture A flag");
      idle(2);
      bus_read(4'd2, 8'h00, "R10 held pin does not retrigger");
      bus_read(4'd10, 8'hEF, "R10 capture A lo");
      bus_read(4'd11, 8'h11, "R10 capture A hi");
      cap_pin_a = 1'b0;

      // capture B
      cap_pin_b = 1'b1;
      idle(1);
      cap_pin_b = 1'b0;
      bus_read(4'd2, 8'h04, "R10 capture B flag");
      bus_read(4'd12, 8'hEF, "R10 capture B lo");
      bus_read(4'd13, 8'h11, "R10 capture B hi");

      // trip strobe
      trip_strobe = 1'b1;
      idle(1);
      trip_strobe = 1'b0;
      bus_read(4'd2, 8'h02, "R11 trip sets capture A flag");
      // trip in the same cycle as a status read
      trip_strobe = 1'b1;
      bus_read(4'd2, 8'h00, "R3 read during event returns old flags");
      trip_strobe = 1'b0;
      bus_read(4'd2, 8'h02, "R3 same-cycle event survives read");

      // new reload 2; run to zero then reload
      bus_write(4'd0, 8'h02);
      bus_write(4'd1, 8'h00);
      bus_read(4'd0, 8'hEF, "R6 count lo kept after reload write");
      bus_read(4'd1, 8'h11, "R6 count hi kept after reload write");
      run_ticks(16'h11F0);
      bus_read(4'd2, 8'h21, "R4 end-of-count with compare 2");
      bus_read(4'd0, 8'h02, "R4 reload lo after wrap");
      bus_read(4'd1, 8'h00, "R4 reload hi after wrap");
      run_ticks(3);
      bus_read(4'd2, 8'h01, "R4 second wrap flag");
      bus_read(4'd0, 8'h02, "R4 second wrap count");
      idle(2);

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule